// File: doc/BRIEF.md
# Compare-Waveform Timer Channel

This block is one up-counting timer channel for timekeeping work: a free-running time base, a periodic tick or a one-shot delay. Its counting clock comes from one of four prescaled taps of the system clock, from a slow clock, or from an external chained clock. The slow and external clocks are synchronised into the system clock domain, and the counter advances once for each rising edge they present.

Three compare values act on the channel. RC can wrap the counter back to zero or stop it. RA and RC can drive a waveform output pin, as can a software trigger. Four sticky event flags are collected in a status word that clears when it is read. Each flag reaches the interrupt line when its mask bit is set, and the mask bits are set and cleared through separate write-one registers.

Software uses a simple single-cycle register port. A write with `wr_en` takes effect at the next clock edge. Read data is combinational while `rd_en` is high.

Top module: `tmr_wave_chan`

## Requirements
- R1: The clock selection field MODE[2:0] chooses the counting clock. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 system clocks. Value 4 counts rising edges of `slow_clk` and value 5 counts rising edges of `ext_clk`. Values 6 and 7 give no ticks. The counter advances by one per tick while the clock is active.
- R2: In free-run mode (MODE[4:3] = 0) the counter wraps from all ones to zero. The wrapping tick sets status flag bit 0.
- R3: In auto-reset mode (MODE[4:3] = 1) a tick that arrives while the counter equals RC returns the counter to zero, so the period is RC+1 ticks. That tick sets status flag bit 3.
- R4: With MODE[5] set, an RC match clears the clock-active state after the match. The counter then holds its value until a software trigger starts it again.
- R5: In CTRL (address 0), bit 0 enables the clock and bit 1 disables it. Disable wins when both are written together. STATUS bit 8 reads 1 while the clock is active. While the clock is inactive the counter value does not change.
- R6: CTRL bit 2 is a software trigger. It clears the counter to zero and makes the clock active, and it may be written together with bit 0.
- R7: The waveform output has three action fields: trigger MODE[7:6], RA compare MODE[9:8] and RC compare MODE[11:10]. The codes are 0 none, 1 set, 2 clear and 3 toggle. If RA and RC match on the same tick, the RC action applies.
- R8: Writing a one to a bit of IEN (address 7) sets that mask bit. Writing a one to a bit of IDIS (address 8) clears it. IMASK (address 9) reads the mask. Writing 0xFF to IDIS clears the whole mask.
- R9: STATUS (address 6) holds sticky flags: bit 0 wrap, bit 1 RA match, bit 2 RB match, bit 3 RC match. A STATUS read clears them, but an event in the same cycle still sets its flag.
- R10: `irq` is high exactly when some pending flag has its mask bit set.
- R11: A tick that arrives while the counter equals RA (address 2) sets flag bit 1. A tick that arrives while it equals RB (address 3) sets flag bit 2. RC is at address 4, MODE at address 1 and the counter reads at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow clock, selectable as counting source |
| ext_clk | input | 1 | External chained clock, selectable as counting source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rd_en is high |
| wave_out | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with an 8-bit counter. This brings the full-width wrap and the wrap flag within about 512 system clocks on the fastest tap, which a 16-bit default would push past 130,000. Every other parameter keeps its default, so all four prescale taps, both synchronised clock inputs and the full 32-bit register port are exercised as built. The bench measures tick counts over whole multiples of the tap period, so its expected values do not depend on the free-running prescaler's phase.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NFLAG    = 4;
  localparam int unsigned MODE_W   = 12;
  localparam int unsigned ACTIVE_BIT = 8;

  localparam int unsigned FL_WRAP = 0;
  localparam int unsigned FL_RA   = 1;
  localparam int unsigned FL_RB   = 2;
  localparam int unsigned FL_RC   = 3;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_RA    = 4'd2;
  localparam logic [3:0] A_RB    = 4'd3;
  localparam logic [3:0] A_RC    = 4'd4;
  localparam logic [3:0] A_CNT   = 4'd5;
  localparam logic [3:0] A_STAT  = 4'd6;
  localparam logic [3:0] A_IEN   = 4'd7;
  localparam logic [3:0] A_IDIS  = 4'd8;
  localparam logic [3:0] A_IMASK = 4'd9;

  localparam logic [1:0] CM_FREE  = 2'd0;
  localparam logic [1:0] CM_RCRST = 2'd1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic [1:0]       rc_act;
    logic [1:0]       ra_act;
    logic [1:0]       trg_act;
    logic             stop_rc;
    logic [1:0]       cnt_mode;
    logic [SEL_W-1:0] clk_sel;
  } mode_t;

  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (pin_act_e'(act))
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
  import tmr_wave_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int unsigned PRESC_W = 2 * NUM_TAPS - 1;
  localparam int unsigned NUM_SRC = 2;

  logic [PRESC_W-1:0]  presc_q, presc_d;
  logic [NUM_TAPS-1:0] tap_tick;
  logic [NUM_SRC-1:0]  src_in;
  logic [NUM_SRC-1:0]  src_rise;

  assign presc_d = presc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap_tick[k] = &presc_q[2*k:0];
  end

  assign src_in = {ext_clk, slow_clk};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_edge
    logic [SYNC_STAGES:0] sh_q, sh_d;
    assign sh_d = {sh_q[SYNC_STAGES-1:0], src_in[s]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign src_rise[s] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  end

  always_comb begin
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: tick = tap_tick[sel[1:0]];
      3'd4:                   tick = src_rise[0];
      3'd5:                   tick = src_rise[1];
      default:                tick = 1'b0;
    endcase
  end

  // R1: with an unchanged selection no two ticks are back to back
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_wave_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic             trig_req,
  input  logic [1:0]       cnt_mode,
  input  logic             stop_rc,
  input  logic [CNT_W-1:0] ra_val,
  input  logic [CNT_W-1:0] rb_val,
  input  logic [CNT_W-1:0] rc_val,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic [NFLAG-1:0] events
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;
  logic             step, hit_ra, hit_rb, hit_rc, rc_wrap;

  always_comb begin
    step    = tick && active_q && !trig_req;
    hit_ra  = step && (cnt_q == ra_val);
    hit_rb  = step && (cnt_q == rb_val);
    hit_rc  = step && (cnt_q == rc_val);
    rc_wrap = hit_rc && (cnt_mode == CM_RCRST);

    events          = '0;
    events[FL_WRAP] = step && (cnt_q == CNT_MAX) && !rc_wrap;
    events[FL_RA]   = hit_ra;
    events[FL_RB]   = hit_rb;
    events[FL_RC]   = hit_rc;

    cnt_d = cnt_q;
    if (trig_req)     cnt_d = '0;
    else if (step)    cnt_d = rc_wrap ? '0 : cnt_q + 1'b1;

    active_d = active_q;
    if (dis_req)                active_d = 1'b0;
    else if (trig_req)          active_d = 1'b1;
    else if (stop_rc && hit_rc) active_d = 1'b0;
    else if (en_req)            active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  assign cnt    = cnt_q;
  assign active = active_q;

  assert_rc_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (events[FL_RC] && cnt_mode == CM_RCRST) |=> (cnt_q == '0));

  assert_rc_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (events[FL_RC] && stop_rc && !dis_req) |=> !active_q);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !trig_req) |=> $stable(cnt_q));

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    events[FL_WRAP] |=> (cnt_q == '0));

  assert_trig_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !dis_req) |=> (active_q && cnt_q == '0));

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
  import tmr_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_req,
  input  logic       hit_ra,
  input  logic       hit_rc,
  input  logic [1:0] trg_act,
  input  logic [1:0] ra_act,
  input  logic [1:0] rc_act,
  output logic       wave
);

  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (trig_req)    wave_d = apply_act(wave_q, trg_act);
    else if (hit_rc) wave_d = apply_act(wave_q, rc_act);
    else if (hit_ra) wave_d = apply_act(wave_q, ra_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  assert_trig_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && trg_act == ACT_SET) |=> wave_q);

  assert_rc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_req && hit_rc && rc_act == ACT_CLR) |=> !wave_q);

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_wave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] events,
  input  logic             rd_clr,
  input  logic             ien_we,
  input  logic             idis_we,
  input  logic [NFLAG-1:0] wbits,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] mask,
  output logic             irq
);

  logic [NFLAG-1:0] flags_q, flags_d;
  logic [NFLAG-1:0] mask_q, mask_d;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | events;
    mask_d  = mask_q;
    if (idis_we) mask_d = mask_d & ~wbits;
    if (ien_we)  mask_d = mask_d | wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
    end
  end

  assign flags = flags_q;
  assign mask  = mask_q;
  assign irq   = |(flags_q & mask_q);

  assert_disable_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idis_we && !ien_we && (&wbits)) |=> (mask_q == '0));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && events == '0) |=> (flags_q == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((flags_q & $past(events)) == $past(events)));

endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_wave_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wave_out,
  output logic              irq
);

  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_DIS = 1;
  localparam int unsigned CTRL_TRG = 2;

  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] ra_q, ra_d, rb_q, rb_d, rc_q, rc_d;
  logic             we_ctrl, we_mode, we_ra, we_rb, we_rc, we_ien, we_idis, rd_clr;
  logic             en_req, dis_req, trig_req;
  logic             tick, active;
  logic [CNT_W-1:0] cnt;
  logic [NFLAG-1:0] events, flags, mask;

  always_comb begin
    we_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    we_mode = wr_en && (addr == ADDR_W'(A_MODE));
    we_ra   = wr_en && (addr == ADDR_W'(A_RA));
    we_rb   = wr_en && (addr == ADDR_W'(A_RB));
    we_rc   = wr_en && (addr == ADDR_W'(A_RC));
    we_ien  = wr_en && (addr == ADDR_W'(A_IEN));
    we_idis = wr_en && (addr == ADDR_W'(A_IDIS));
    rd_clr  = rd_en && (addr == ADDR_W'(A_STAT));
    en_req   = we_ctrl && wdata[CTRL_EN];
    dis_req  = we_ctrl && wdata[CTRL_DIS];
    trig_req = we_ctrl && wdata[CTRL_TRG];
  end

  always_comb begin
    mode_d = we_mode ? mode_t'(wdata[MODE_W-1:0]) : mode_q;
    ra_d   = we_ra ? wdata[CNT_W-1:0] : ra_q;
    rb_d   = we_rb ? wdata[CNT_W-1:0] : rb_q;
    rc_d   = we_rc ? wdata[CNT_W-1:0] : rc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rc_q   <= '0;
    end else begin
      mode_q <= mode_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
      rc_q   <= rc_d;
    end
  end

  tmr_clk_select u_clk_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .ext_clk  (ext_clk),
    .sel      (mode_q.clk_sel),
    .tick     (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en_req   (en_req),
    .dis_req  (dis_req),
    .trig_req (trig_req),
    .cnt_mode (mode_q.cnt_mode),
    .stop_rc  (mode_q.stop_rc),
    .ra_val   (ra_q),
    .rb_val   (rb_q),
    .rc_val   (rc_q),
    .cnt      (cnt),
    .active   (active),
    .events   (events)
  );

  tmr_wave_out u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_req (trig_req),
    .hit_ra   (events[FL_RA]),
    .hit_rc   (events[FL_RC]),
    .trg_act  (mode_q.trg_act),
    .ra_act   (mode_q.ra_act),
    .rc_act   (mode_q.rc_act),
    .wave     (wave_out)
  );

  tmr_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .events  (events),
    .rd_clr  (rd_clr),
    .ien_we  (we_ien),
    .idis_we (we_idis),
    .wbits   (wdata[NFLAG-1:0]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(A_MODE):  rdata[MODE_W-1:0] = mode_q;
        ADDR_W'(A_RA):    rdata[CNT_W-1:0]  = ra_q;
        ADDR_W'(A_RB):    rdata[CNT_W-1:0]  = rb_q;
        ADDR_W'(A_RC):    rdata[CNT_W-1:0]  = rc_q;
        ADDR_W'(A_CNT):   rdata[CNT_W-1:0]  = cnt;
        ADDR_W'(A_STAT): begin
          rdata[NFLAG-1:0]  = flags;
          rdata[ACTIVE_BIT] = active;
        end
        ADDR_W'(A_IMASK): rdata[NFLAG-1:0]  = mask;
        default:          rdata = '0;
      endcase
    end
  end

  // R10: a pending enabled flag drives the interrupt line
  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & mask) != '0) |-> irq);

endmodule

// File: tb/tmr_wave_chan_tb_top.sv
module tmr_wave_chan_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  localparam logic [3:0] A_CTRL = 0, A_MODE = 1, A_RA = 2, A_RB = 3, A_RC = 4,
                         A_CNT = 5, A_STAT = 6, A_IEN = 7, A_IDIS = 8, A_IMASK = 9;
  localparam logic [31:0] EN = 1, DIS = 2, TRG = 4;

  logic clk, rst_n, slow_clk, ext_clk, wr_en, rd_en, wave_out, irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  int n_chk, n_err;

  tmr_wave_chan #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .ext_clk(ext_clk),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wave_out(wave_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_mode(int sel, int cm, int stp, int trg, int ra, int rc);
    return 32'((rc << 10) | (ra << 8) | (trg << 6) | (stp << 5) | (cm << 3) | sel);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(input bit use_ext, input int n);
    for (int i = 0; i < n; i++) begin
      if (use_ext) ext_clk = 1'b1; else slow_clk = 1'b1;
      idle(3);
      if (use_ext) ext_clk = 1'b0; else slow_clk = 1'b0;
      idle(3);
    end
  endtask

  task automatic quiesce();
    logic [31:0] v;
    wr(A_CTRL, DIS);
    rd(A_STAT, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v);   check("R5 reset count", v, 0);
    rd(A_STAT, v);  check("R9 reset status", v, 0);
    rd(A_IMASK, v); check("R8 reset mask", v, 0);
    check("R7 reset wave", {31'b0, wave_out}, 0);
    check("R10 reset irq", {31'b0, irq}, 0);
  endtask

  task automatic t_taps();
    logic [31:0] v;
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CTRL, EN | TRG); idle(20); rd(A_CNT, v);
    check("R1 R6 tap div2", v, 10);
    rd(A_STAT, v); check("R5 active bit", v & 32'h100, 32'h100);
    wr(A_MODE, mk_mode(1, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); idle(40); rd(A_CNT, v);
    check("R1 tap div8", v, 5);
    wr(A_MODE, mk_mode(3, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); idle(256); rd(A_CNT, v);
    check("R1 tap div128", v, 2);
    wr(A_MODE, mk_mode(6, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); idle(20); rd(A_CNT, v);
    check("R1 unused select", v, 0);
  endtask

  task automatic t_sources();
    logic [31:0] v;
    wr(A_MODE, mk_mode(4, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); pulse_src(1'b0, 4); idle(4); rd(A_CNT, v);
    check("R1 slow clock", v, 4);
    wr(A_MODE, mk_mode(5, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); pulse_src(1'b1, 3); pulse_src(1'b0, 2); idle(4); rd(A_CNT, v);
    check("R1 ext clock", v, 3);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    quiesce();
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CTRL, TRG); idle(510); rd(A_STAT, v);
    check("R2 no wrap before full", v & 1, 0);
    idle(1); rd(A_STAT, v);
    check("R2 wrap flag", v & 1, 1);
  endtask

  task automatic t_rcreset();
    logic [31:0] v;
    quiesce();
    wr(A_RC, 9);
    wr(A_MODE, mk_mode(0, 1, 0, 0, 0, 0));
    wr(A_CTRL, EN | TRG); idle(50); rd(A_CNT, v);
    check("R3 auto reset count", v, 5);
    rd(A_STAT, v); check("R3 rc flag", v & 8, 8);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(A_RC, 5);
    wr(A_MODE, mk_mode(0, 0, 1, 0, 0, 0));
    wr(A_CTRL, TRG); idle(30); rd(A_CNT, v);
    check("R4 stopped count", v, 6);
    rd(A_STAT, v); check("R4 clock inactive", v & 32'h108, 32'h008);
    idle(10); rd(A_CNT, v); check("R4 still held", v, 6);
    wr(A_CTRL, TRG); idle(4); rd(A_CNT, v);
    check("R4 R6 retrigger", v, 2);
  endtask

  task automatic t_endis();
    logic [31:0] v, w;
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CTRL, EN | TRG); idle(10);
    wr(A_CTRL, DIS); rd(A_CNT, v); idle(10); rd(A_CNT, w);
    check("R5 disabled holds", w, v);
    rd(A_STAT, w); check("R5 inactive bit", w & 32'h100, 0);
    wr(A_CTRL, EN | DIS); rd(A_STAT, w);
    check("R5 disable wins", w & 32'h100, 0);
    wr(A_CTRL, EN); idle(20); rd(A_CNT, w);
    check("R5 enable resumes", w, v + 10);
  endtask

  task automatic t_wave();
    logic [31:0] v;
    wr(A_RA, 3); wr(A_RC, 7);
    wr(A_MODE, mk_mode(0, 1, 0, 1, 0, 0));
    wr(A_CTRL, EN | TRG);
    check("R7 trigger set", {31'b0, wave_out}, 1);
    wr(A_MODE, mk_mode(0, 1, 0, 2, 1, 2));
    wr(A_CTRL, TRG);
    check("R7 trigger clear", {31'b0, wave_out}, 0);
    idle(10); check("R7 ra set", {31'b0, wave_out}, 1);
    idle(8);  check("R7 rc clear", {31'b0, wave_out}, 0);
    wr(A_RA, 2); wr(A_RC, 2);
    wr(A_MODE, mk_mode(0, 1, 0, 1, 2, 1));
    wr(A_CTRL, TRG); idle(10);
    check("R7 rc over ra", {31'b0, wave_out}, 1);
    rd(A_CNT, v);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    quiesce();
    wr(A_IEN, 8); rd(A_IMASK, v); check("R8 enable bit", v, 8);
    wr(A_IEN, 1); rd(A_IMASK, v); check("R8 enable accumulates", v, 9);
    check("R10 no pending", {31'b0, irq}, 0);
    wr(A_RC, 3);
    wr(A_MODE, mk_mode(0, 1, 0, 0, 0, 0));
    wr(A_CTRL, EN | TRG); idle(20);
    check("R10 irq raised", {31'b0, irq}, 1);
    wr(A_IDIS, 32'hFF); rd(A_IMASK, v); check("R8 disable all", v, 0);
    check("R10 masked", {31'b0, irq}, 0);
    wr(A_IEN, 8); check("R10 sticky re-enable", {31'b0, irq}, 1);
    quiesce();
    check("R9 read clears irq", {31'b0, irq}, 0);
    rd(A_STAT, v); check("R9 cleared flags", v, 0);
    wr(A_IDIS, 32'hFF);
  endtask

  task automatic t_rarb();
    logic [31:0] v;
    quiesce();
    wr(A_RA, 4); wr(A_RB, 6); wr(A_RC, 200);
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CTRL, EN | TRG); idle(10); rd(A_STAT, v);
    check("R11 ra flag only", v & 6, 2);
    idle(4); rd(A_STAT, v);
    check("R11 rb flag", v & 4, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; slow_clk = 1'b0; ext_clk = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_taps();
    t_sources();
    t_wrap();
    t_rcreset();
    t_stop();
    t_endis();
    t_wave();
    t_irq();
    t_rarb();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule